// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit

This block is the data-path arithmetic unit of a small accumulator-based controller. On each cycle where `go` is high it takes the accumulator byte, a second operand byte, the B register byte and the incoming carry, auxiliary-carry and overflow flags. It evaluates the operation selected by a 5-bit code and registers a new accumulator, a new B value, the three flags, and a not-equal indication for compare-and-branch. When `go` is low every output holds its value.

The surrounding controller handles fetching, decoding and operand addressing. It presents the operands, pulses `go`, and one clock later writes back `acc_out`, `b_out` and the flags. When an operation does not change a flag, the flag input is passed through. When an operation does not change B, `b_in` is passed through. This lets the controller write back unconditionally.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, every output is zero. Each result appears on the outputs one clock after the edge at which `go` was high. While `go` is low, all outputs keep their values. Op codes 19 to 31 return `acc_in`, `b_in` and the incoming flags unchanged, with `ne_out` low.
- R2: Code 0 (add) returns A+operand and code 1 (add with carry) returns A+operand+CY. For both, CY is the carry out of bit 7, AC is the carry from bit 3 into bit 4, and OV is set on signed two's-complement overflow.
- R3: Code 2 (subtract with borrow) returns A−operand−CY. CY is set when a borrow leaves bit 7, AC is set when a borrow crosses from bit 4 into bit 3, and OV is set on signed overflow.
- R4: Code 3 (decimal adjust) first adds 06h when the low nibble of A exceeds 9 or AC is set. It then adds 60h when the high nibble of the intermediate value exceeds 9, or when CY is set, or when the first step carried out. CY is set when either step carries out and is never cleared. AC and OV pass through.
- R5: Code 4 increments A and code 5 decrements A, both wrapping modulo 256. The flags pass through.
- R6: Code 6 (AND), code 7 (OR) and code 8 (XOR) combine A with the operand. Code 9 inverts A and code 10 clears A. The flags pass through.
- R7: Code 11 rotates A left and code 12 rotates A right, each by one bit, with the flags passing through. Code 13 rotates the 9-bit value {CY,A} left and code 14 rotates it right, with CY taking the bit shifted out of A.
- R8: Code 15 exchanges bits 7:4 of A with bits 3:0.
- R9: Code 16 (compare) leaves A unchanged. It sets CY when A is below the operand as unsigned numbers and sets `ne_out` when A differs from the operand. AC and OV pass through. For every code other than 16, `ne_out` is low.
- R10: Code 17 (multiply) forms A×B. The low byte goes to A and the high byte to B. CY is cleared, OV is set when the product exceeds 255, and AC passes through.
- R11: Code 18 (divide) places the quotient of A/B in A and the remainder in B, and clears CY and OV. When B is zero, A and B are returned unchanged, OV is set and CY is cleared. AC passes through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Evaluate the operation this cycle |
| op | input | 5 | Operation code |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand |
| b_in | input | 8 | B register operand for multiply and divide |
| cy_in | input | 1 | Incoming carry flag |
| ac_in | input | 1 | Incoming auxiliary-carry flag |
| ov_in | input | 1 | Incoming overflow flag |
| acc_out | output | 8 | New accumulator value |
| b_out | output | 8 | New B register value |
| cy_out | output | 1 | New carry flag |
| ac_out | output | 1 | New auxiliary-carry flag |
| ov_out | output | 1 | New overflow flag |
| ne_out | output | 1 | Compare found the operands unequal |

## Verification
The unit has no parameters, so the bench builds it in its only configuration, with an 8-bit data path and a 5-bit code. This puts the full operand range within reach. Directed cases cover products of 255×255, division by zero, compares at equality and one step either side, and decimal adjust at the 99h boundary. A long random run then covers every code, including the unused ones, and toggles `go` to check that the outputs hold.

// File: rtl/acc_alu.sv
module acc_alu (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [4:0] op,
  input  logic [7:0] acc_in,
  input  logic [7:0] opnd_in,
  input  logic [7:0] b_in,
  input  logic       cy_in,
  input  logic       ac_in,
  input  logic       ov_in,
  output logic [7:0] acc_out,
  output logic [7:0] b_out,
  output logic       cy_out,
  output logic       ac_out,
  output logic       ov_out,
  output logic       ne_out
);

  localparam logic [4:0] K_ADD  = 5'd0,  K_ADDC = 5'd1,  K_SUBB = 5'd2,  K_DA   = 5'd3;
  localparam logic [4:0] K_INC  = 5'd4,  K_DEC  = 5'd5,  K_AND  = 5'd6,  K_OR   = 5'd7;
  localparam logic [4:0] K_XOR  = 5'd8,  K_CPL  = 5'd9,  K_CLR  = 5'd10, K_RL   = 5'd11;
  localparam logic [4:0] K_RR   = 5'd12, K_RLC  = 5'd13, K_RRC  = 5'd14, K_SWAP = 5'd15;
  localparam logic [4:0] K_CMP  = 5'd16, K_MUL  = 5'd17, K_DIV  = 5'd18;

  logic       add_cin;
  logic [8:0] sum, dif, s1, s2;
  logic       sum_ov, dif_ov, lo_fix, hi_fix;
  logic [15:0] prod;
  logic [7:0] dvsr, quo, rem;

  assign add_cin = (op == K_ADDC) & cy_in;
  assign sum     = {1'b0, acc_in} + {1'b0, opnd_in} + {8'b0, add_cin};
  assign dif     = {1'b0, acc_in} - {1'b0, opnd_in} - {8'b0, cy_in};
  assign sum_ov  = (acc_in[7] == opnd_in[7]) && (sum[7] != acc_in[7]);
  assign dif_ov  = (acc_in[7] != opnd_in[7]) && (dif[7] != acc_in[7]);

  assign lo_fix  = (acc_in[3:0] > 4'd9) | ac_in;
  assign s1      = {1'b0, acc_in} + (lo_fix ? 9'h006 : 9'h000);
  assign hi_fix  = (s1[7:4] > 4'd9) | cy_in | s1[8];
  assign s2      = {1'b0, s1[7:0]} + (hi_fix ? 9'h060 : 9'h000);

  assign prod    = {8'b0, acc_in} * {8'b0, b_in};
  assign dvsr    = (b_in == 8'd0) ? 8'd1 : b_in;
  assign quo     = acc_in / dvsr;
  assign rem     = acc_in % dvsr;

  logic [7:0] n_acc, n_b;
  logic       n_cy, n_ac, n_ov, n_ne;

  always_comb begin
    n_acc = acc_in;
    n_b   = b_in;
    n_cy  = cy_in;
    n_ac  = ac_in;
    n_ov  = ov_in;
    n_ne  = 1'b0;
    case (op)
      K_ADD, K_ADDC: begin
        n_acc = sum[7:0];
        n_cy  = sum[8];
        n_ac  = acc_in[4] ^ opnd_in[4] ^ sum[4];
        n_ov  = sum_ov;
      end
      K_SUBB: begin
        n_acc = dif[7:0];
        n_cy  = dif[8];
        n_ac  = acc_in[4] ^ opnd_in[4] ^ dif[4];
        n_ov  = dif_ov;
      end
      K_DA: begin
        n_acc = s2[7:0];
        n_cy  = cy_in | s1[8] | s2[8];
      end
      K_INC:  n_acc = acc_in + 8'd1;
      K_DEC:  n_acc = acc_in - 8'd1;
      K_AND:  n_acc = acc_in & opnd_in;
      K_OR:   n_acc = acc_in | opnd_in;
      K_XOR:  n_acc = acc_in ^ opnd_in;
      K_CPL:  n_acc = ~acc_in;
      K_CLR:  n_acc = 8'd0;
      K_RL:   n_acc = {acc_in[6:0], acc_in[7]};
      K_RR:   n_acc = {acc_in[0], acc_in[7:1]};
      K_RLC: begin
        n_acc = {acc_in[6:0], cy_in};
        n_cy  = acc_in[7];
      end
      K_RRC: begin
        n_acc = {cy_in, acc_in[7:1]};
        n_cy  = acc_in[0];
      end
      K_SWAP: n_acc = {acc_in[3:0], acc_in[7:4]};
      K_CMP: begin
        n_cy = acc_in < opnd_in;
        n_ne = acc_in != opnd_in;
      end
      K_MUL: begin
        n_acc = prod[7:0];
        n_b   = prod[15:8];
        n_cy  = 1'b0;
        n_ov  = prod[15:8] != 8'd0;
      end
      K_DIV: begin
        n_cy = 1'b0;
        if (b_in == 8'd0) begin
          n_ov = 1'b1;
        end else begin
          n_acc = quo;
          n_b   = rem;
          n_ov  = 1'b0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_out <= 8'd0;
      b_out   <= 8'd0;
      cy_out  <= 1'b0;
      ac_out  <= 1'b0;
      ov_out  <= 1'b0;
      ne_out  <= 1'b0;
    end else if (go) begin
      acc_out <= n_acc;
      b_out   <= n_b;
      cy_out  <= n_cy;
      ac_out  <= n_ac;
      ov_out  <= n_ov;
      ne_out  <= n_ne;
    end
  end

  // R1
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(acc_out) && $stable(b_out) && $stable({cy_out, ac_out, ov_out, ne_out}));

  // R9
  cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == K_CMP) |=> (acc_out == $past(acc_in)) && (!cy_out || ne_out));

  // R9
  ne_only_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op != K_CMP) |=> !ne_out);

  // R10
  mul_clears_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == K_MUL) |=> !cy_out && (ov_out == (b_out != 8'd0)));

  // R11
  div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == K_DIV && b_in == 8'd0) |=> ov_out && !cy_out && acc_out == $past(acc_in) && b_out == 8'd0);

  // R11
  div_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == K_DIV && b_in != 8'd0) |=> (b_out < $past(b_in)) && !ov_out && !cy_out);

  // R7
  rlc_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == K_RLC) |=> cy_out == $past(acc_in[7]) && acc_out[0] == $past(cy_in));

endmodule

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, go, cy_in, ac_in, ov_in;
  logic [4:0] op;
  logic [7:0] acc_in, opnd_in, b_in;
  logic [7:0] acc_out, b_out;
  logic       cy_out, ac_out, ov_out, ne_out;

  acc_alu dut (
    .clk(clk), .rst_n(rst_n), .go(go), .op(op),
    .acc_in(acc_in), .opnd_in(opnd_in), .b_in(b_in),
    .cy_in(cy_in), .ac_in(ac_in), .ov_in(ov_in),
    .acc_out(acc_out), .b_out(b_out), .cy_out(cy_out),
    .ac_out(ac_out), .ov_out(ov_out), .ne_out(ne_out)
  );

  int total = 0;
  int bad = 0;
  int e_acc, e_b, e_cy, e_ac, e_ov, e_ne;
  string e_tag = "R1";
  bit done = 1'b0;

  function automatic string tag_of(int code);
    case (code)
      0, 1: return "R2";
      2: return "R3";
      3: return "R4";
      4, 5: return "R5";
      6, 7, 8, 9, 10: return "R6";
      11, 12, 13, 14: return "R7";
      15: return "R8";
      16: return "R9";
      17: return "R10";
      18: return "R11";
      default: return "R1";
    endcase
  endfunction

  function automatic int sx(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  task automatic model(input int code, input int a, input int o, input int b,
                       input int c, input int h, input int v);
    int t, sv;
    e_acc = a; e_b = b; e_cy = c; e_ac = h; e_ov = v; e_ne = 0;
    case (code)
      0, 1: begin
        t = a + o + ((code == 1) ? c : 0);
        e_acc = t % 256; e_cy = (t > 255);
        e_ac = ((a % 16) + (o % 16) + ((code == 1) ? c : 0)) > 15;
        sv = sx(a) + sx(o) + ((code == 1) ? c : 0);
        e_ov = (sv > 127 || sv < -128);
      end
      2: begin
        t = a - o - c;
        e_acc = (t + 512) % 256; e_cy = (t < 0);
        e_ac = ((a % 16) - (o % 16) - c) < 0;
        sv = sx(a) - sx(o) - c;
        e_ov = (sv > 127 || sv < -128);
      end
      3: begin
        t = a;
        if ((a % 16) > 9 || h) t = t + 6;
        if (t > 255) e_cy = 1;
        t = t % 256;
        if ((t / 16) > 9 || e_cy) t = t + 96;
        if (t > 255) e_cy = 1;
        e_acc = t % 256;
      end
      4: e_acc = (a + 1) % 256;
      5: e_acc = (a + 255) % 256;
      6: e_acc = a & o;
      7: e_acc = a | o;
      8: e_acc = a ^ o;
      9: e_acc = 255 - a;
      10: e_acc = 0;
      11: e_acc = ((a * 2) % 256) + (a / 128);
      12: e_acc = (a / 2) + ((a % 2) * 128);
      13: begin e_acc = ((a * 2) % 256) + c; e_cy = a / 128; end
      14: begin e_acc = (a / 2) + c * 128; e_cy = a % 2; end
      15: e_acc = (a % 16) * 16 + a / 16;
      16: begin e_cy = (a < o); e_ne = (a != o); end
      17: begin
        t = a * b; e_acc = t % 256; e_b = t / 256; e_cy = 0; e_ov = (t > 255);
      end
      18: begin
        e_cy = 0;
        if (b == 0) e_ov = 1;
        else begin e_acc = a / b; e_b = a % b; e_ov = 0; end
      end
      default: ;
    endcase
  endtask

  task automatic compare();
    total++;
    if (acc_out !== 8'(e_acc) || b_out !== 8'(e_b) || cy_out !== 1'(e_cy) ||
        ac_out !== 1'(e_ac) || ov_out !== 1'(e_ov) || ne_out !== 1'(e_ne)) begin
      bad++;
      $display("FAIL %s: got acc=%02h b=%02h cy=%0d ac=%0d ov=%0d ne=%0d expected acc=%02h b=%02h cy=%0d ac=%0d ov=%0d ne=%0d",
               e_tag, acc_out, b_out, cy_out, ac_out, ov_out, ne_out,
               e_acc, e_b, e_cy, e_ac, e_ov, e_ne);
    end
  endtask

  task automatic step(input int code, input int a, input int o, input int b,
                      input int c, input int h, input int v, input bit g);
    @(negedge clk);
    compare();
    go = g; op = 5'(code); acc_in = 8'(a); opnd_in = 8'(o); b_in = 8'(b);
    cy_in = c[0]; ac_in = h[0]; ov_in = v[0];
    if (g) begin
      model(code, a, o, b, c, h, v);
      e_tag = tag_of(code);
    end else begin
      e_tag = "R1";
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1: watchdog expired, got no completion expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; go = 1'b1; op = 5'd4; acc_in = 8'h5A; opnd_in = 8'h33;
    b_in = 8'h77; cy_in = 1'b1; ac_in = 1'b1; ov_in = 1'b1;
    e_acc = 0; e_b = 0; e_cy = 0; e_ac = 0; e_ov = 0; e_ne = 0;
    repeat (3) @(negedge clk);
    compare();                       // R1 reset state
    rst_n = 1'b1; go = 1'b0;

    step(0, 8'h7F, 8'h01, 0, 1, 0, 0, 1);   // R2 signed overflow, AC
    step(0, 8'hFF, 8'h01, 0, 0, 0, 0, 1);   // R2 carry out
    step(1, 8'hFF, 8'h00, 0, 1, 0, 0, 1);   // R2 carry chained
    step(1, 8'h80, 8'h80, 0, 0, 0, 0, 1);   // R2 negative overflow
    step(2, 8'h00, 8'h00, 0, 1, 0, 0, 1);   // R3 borrow by CY only
    step(2, 8'h80, 8'h01, 0, 0, 0, 0, 1);   // R3 signed overflow
    step(2, 8'h50, 8'h20, 0, 0, 0, 0, 1);   // R3 plain
    step(3, 8'h9A, 0, 0, 0, 0, 0, 1);       // R4 99+01 binary result
    step(3, 8'h22, 0, 0, 1, 1, 0, 1);       // R4 carry and aux set
    step(3, 8'hFA, 0, 0, 0, 0, 1, 1);       // R4 first step carries
    step(3, 8'h45, 0, 0, 0, 0, 0, 1);       // R4 no adjust
    step(4, 8'hFF, 0, 0, 1, 0, 1, 1);       // R5 wrap up
    step(5, 8'h00, 0, 0, 0, 1, 0, 1);       // R5 wrap down
    step(6, 8'hF0, 8'h3C, 0, 1, 1, 1, 1);   // R6
    step(7, 8'hF0, 8'h0C, 0, 0, 0, 0, 1);   // R6
    step(8, 8'hFF, 8'h0F, 0, 0, 1, 0, 1);   // R6
    step(9, 8'hA5, 0, 0, 0, 0, 0, 1);       // R6
    step(10, 8'hA5, 0, 0, 1, 0, 0, 1);      // R6
    step(11, 8'h81, 0, 0, 0, 0, 0, 1);      // R7
    step(12, 8'h81, 0, 0, 0, 0, 0, 1);      // R7
    step(13, 8'h80, 0, 0, 0, 0, 0, 1);      // R7
    step(14, 8'h01, 0, 0, 1, 0, 0, 1);      // R7
    step(15, 8'h3C, 0, 0, 0, 0, 0, 1);      // R8
    step(16, 8'h10, 8'h10, 0, 1, 0, 0, 1);  // R9 equal
    step(16, 8'h0F, 8'h10, 0, 0, 0, 0, 1);  // R9 below
    step(16, 8'h11, 8'h10, 0, 1, 0, 0, 1);  // R9 above
    step(17, 8'hFF, 0, 8'hFF, 1, 0, 0, 1);  // R10 max product
    step(17, 8'h0F, 0, 8'h11, 1, 0, 1, 1);  // R10 fits a byte
    step(18, 8'hC8, 0, 8'h07, 1, 0, 1, 1);  // R11
    step(18, 8'h42, 0, 8'h00, 1, 0, 0, 1);  // R11 divide by zero
    step(18, 8'h05, 0, 8'h09, 0, 0, 0, 1);  // R11 zero quotient
    step(25, 8'h12, 8'h34, 8'h56, 1, 1, 1, 1); // R1 unused code
    step(0, 8'h11, 8'h22, 0, 0, 0, 0, 0);   // R1 hold with go low
    step(0, 8'h11, 8'h22, 0, 0, 0, 0, 0);   // R1 hold with go low

    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(31), $urandom_range(255), $urandom_range(255),
           (i % 7 == 0) ? 0 : $urandom_range(255), $urandom_range(1),
           $urandom_range(1), $urandom_range(1), ($urandom_range(3) != 0));
    end
    @(negedge clk);
    compare();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule